// File: doc/BRIEF.md
# Periodic Down-Counting Timer with Prescaler and Free-Running Counter

This block is a register-mapped interval timer on a simple single-cycle 32-bit register bus. A down-counter decrements once per decrement tick. The tick rate is set in two stages: a 9-bit predivider counts bus clock cycles, and a fixed prescale of 1, 16 or 256 counts predivider ticks. The counter always runs in periodic mode. On a tick that finds the count at zero, it reloads from the reload value and latches a raw interrupt flag. An interrupt enable masks that flag onto the interrupt pin. Software can write the reload value in two ways. The first restarts the current count at once. The second, a deferred form, only changes what the next wrap loads.

The same register block holds a free-running 32-bit up-counter. It has its own enable bit and its own 8-bit clock divider in the control word. A debug-halt input freezes both counters, but only when the control word allows it. Every access completes in the cycle in which it is presented, so the bus has no back-pressure. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high. Read data is combinational from the address. Only word-aligned addresses decode.

Top module: `ptm_timer`

## Requirements
- R1: After reset every readable register returns zero, the timer and the free-running counter are stopped, and `irq` is low.
- R2: Word offsets are 0x00 reload, 0x04 current count, 0x08 control, 0x0C interrupt clear, 0x10 raw status (bit 0), 0x14 masked status (bit 0), 0x18 deferred reload, 0x1C predivider and 0x20 free-running count. Writes to 0x04 have no effect, 0x0C reads zero, and an address with bit 1 or bit 0 set neither writes nor reads.
- R3: Each decrement tick lowers the count by one. A tick that finds the count at zero loads the reload value instead and sets the raw flag, so one period spans reload+1 ticks.
- R4: The timer runs only while control bit 7 is set. It then ticks every (predivider+1)×S bus cycles, where control bits 3:2 give S: 00 gives 1, 01 gives 16, and 10 or 11 give 256. The predivider register holds 9 bits. Clearing bit 7 holds the count and restarts both dividers.
- R5: With control bit 1 clear, the count is 16 bits wide: offset 0x04 reads only the low 16 bits, and the zero test, the decrement and the reload use only those bits. With bit 1 set, all 32 bits count.
- R6: A write to offset 0x00 sets the reload value and loads the current count on the same edge, and it restarts the predivider and the prescaler.
- R7: A write to offset 0x18 changes only the reload value, which reads back at both 0x00 and 0x18. The running count is untouched until its next wrap.
- R8: A write of any value to 0x0C clears the raw flag, but a wrap on the same edge wins. The masked status and the `irq` pin both equal the raw flag AND control bit 5.
- R9: Control bit 9 enables the free-running counter. It then increments once every (D+1) bus cycles, where D is control bits 23:16, and it keeps its value while disabled.
- R10: While control bit 8 is set and `dbg_halt` is high, both counters and their dividers hold. With bit 8 clear, `dbg_halt` has no effect.
- R11: Control keeps only bits 1, 2, 3, 5, 7, 8, 9 and 23:16, and all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | High for a write when `bus_sel` is high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Masked timer interrupt |

## Verification
The bench uses the default parameters: a 6-bit address, a 9-bit predivider and an 8-bit free-running divider. With these, all nine registers, the full control readback mask and a predivider readback truncated to 0x1FF are in reach. At these widths the divide-by-256 prescale takes only 256 cycles, so each prescale setting is checked at its exact first-tick cycle. The 16-bit mode is checked against a reload value with upper bits set, and the difference from 32-bit counting appears after two ticks. The full predivider range is checked through readback only.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int WORD_W = 32;

  // word indices (byte offset / 4)
  localparam int IX_RELOAD = 0;
  localparam int IX_COUNT  = 1;
  localparam int IX_CTRL   = 2;
  localparam int IX_ACK    = 3;
  localparam int IX_RAW    = 4;
  localparam int IX_MASKED = 5;
  localparam int IX_DEFER  = 6;
  localparam int IX_PREDIV = 7;
  localparam int IX_FREE   = 8;

  // control word bit positions
  localparam int CB_WIDE    = 1;
  localparam int CB_SCALE   = 2;
  localparam int CB_IRQ_EN  = 5;
  localparam int CB_RUN     = 7;
  localparam int CB_DBG     = 8;
  localparam int CB_FREE_EN = 9;
  localparam int CB_FREE_DV = 16;

  typedef enum logic [1:0] {
    SCL_DIV1   = 2'b00,
    SCL_DIV16  = 2'b01,
    SCL_DIV256 = 2'b10,
    SCL_SPARE  = 2'b11
  } scale_e;
endpackage

// File: rtl/ptm_regs.sv
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PREDIV_W = 9,
  parameter int FRDIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                wrap,
  input  logic [WORD_W-1:0]   count_val,
  input  logic [WORD_W-1:0]   free_val,
  output logic [WORD_W-1:0]   reload_val,
  output logic                reload_wr,
  output logic                ctrl_wr,
  output logic                wide,
  output logic [1:0]          scale,
  output logic                irq_en,
  output logic                run_en,
  output logic                dbg_en,
  output logic                free_en,
  output logic [FRDIV_W-1:0]  free_div,
  output logic [PREDIV_W-1:0] prediv,
  output logic                raw_flag
);
  localparam int WX_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] CTRL_KEEP =
    32'h0000_03AE | (((32'd1 << FRDIV_W) - 32'd1) << CB_FREE_DV);

  logic [WX_W-1:0]     wx;
  logic                aligned, wr_any;
  logic                wr_reload, wr_defer, wr_ctrl, wr_ack, wr_pdv;
  logic [WORD_W-1:0]   reload_q, ctrl_q;
  logic [PREDIV_W-1:0] prediv_q;
  logic                raw_q;

  assign wx        = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign wr_any    = bus_sel && bus_wr && aligned;
  assign wr_reload = wr_any && (wx == WX_W'(IX_RELOAD));
  assign wr_defer  = wr_any && (wx == WX_W'(IX_DEFER));
  assign wr_ctrl   = wr_any && (wx == WX_W'(IX_CTRL));
  assign wr_ack    = wr_any && (wx == WX_W'(IX_ACK));
  assign wr_pdv    = wr_any && (wx == WX_W'(IX_PREDIV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      prediv_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      if (wr_reload || wr_defer) reload_q <= bus_wdata;
      if (wr_ctrl)               ctrl_q   <= bus_wdata & CTRL_KEEP;
      if (wr_pdv)                prediv_q <= bus_wdata[PREDIV_W-1:0];
      if (wrap)                  raw_q    <= 1'b1;
      else if (wr_ack)           raw_q    <= 1'b0;
    end
  end

  assign reload_val = reload_q;
  assign reload_wr  = wr_reload;
  assign ctrl_wr    = wr_ctrl;
  assign wide       = ctrl_q[CB_WIDE];
  assign scale      = ctrl_q[CB_SCALE +: 2];
  assign irq_en     = ctrl_q[CB_IRQ_EN];
  assign run_en     = ctrl_q[CB_RUN];
  assign dbg_en     = ctrl_q[CB_DBG];
  assign free_en    = ctrl_q[CB_FREE_EN];
  assign free_div   = ctrl_q[CB_FREE_DV +: FRDIV_W];
  assign prediv     = prediv_q;
  assign raw_flag   = raw_q;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (wx)
        WX_W'(IX_RELOAD): bus_rdata = reload_q;
        WX_W'(IX_COUNT):  bus_rdata = count_val;
        WX_W'(IX_CTRL):   bus_rdata = ctrl_q;
        WX_W'(IX_RAW):    bus_rdata = {31'd0, raw_q};
        WX_W'(IX_MASKED): bus_rdata = {31'd0, raw_q & ctrl_q[CB_IRQ_EN]};
        WX_W'(IX_DEFER):  bus_rdata = reload_q;
        WX_W'(IX_PREDIV): bus_rdata = WORD_W'(prediv_q);
        WX_W'(IX_FREE):   bus_rdata = free_val;
        default:          bus_rdata = '0;
      endcase
    end
  end

  // R8: a wrap always leaves the raw flag set
  a_r8_wrap_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> raw_q);
  // R8: acknowledge without a wrap leaves the flag clear
  a_r8_ack_clears_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !wrap) |=> !raw_q);
endmodule

// File: rtl/ptm_tickgen.sv
module ptm_tickgen
  import ptm_pkg::*;
#(
  parameter int PREDIV_W = 9,
  parameter int SCALE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                hold,
  input  logic                restart,
  input  logic [PREDIV_W-1:0] prediv,
  input  logic [1:0]          scale,
  output logic                dec_tick
);
  logic [PREDIV_W-1:0] pre_q;
  logic [SCALE_W-1:0]  scl_q;
  logic [SCALE_W-1:0]  scl_lim;
  logic                active, pre_hit, scl_hit;

  always_comb begin
    case (scale_e'(scale))
      SCL_DIV1:  scl_lim = '0;
      SCL_DIV16: scl_lim = SCALE_W'(15);
      default:   scl_lim = SCALE_W'(255);
    endcase
  end

  assign active   = enable && !hold;
  assign pre_hit  = (pre_q >= prediv);
  assign scl_hit  = (scl_q >= scl_lim);
  assign dec_tick = active && pre_hit && scl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      scl_q <= '0;
    end else if (!enable || restart) begin
      pre_q <= '0;
      scl_q <= '0;
    end else if (active) begin
      if (pre_hit) begin
        pre_q <= '0;
        scl_q <= scl_hit ? '0 : scl_q + SCALE_W'(1);
      end else begin
        pre_q <= pre_q + PREDIV_W'(1);
      end
    end
  end

  // R6: a restart with a nonzero predivider cannot tick on the next edge
  a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && prediv != '0) |=> !dec_tick);
endmodule

// File: rtl/ptm_down.sv
module ptm_down
  import ptm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_tick,
  input  logic              wide,
  input  logic              load_now,
  input  logic [WORD_W-1:0] load_data,
  input  logic [WORD_W-1:0] reload_val,
  output logic [WORD_W-1:0] count_val,
  output logic              wrap
);
  logic [WORD_W-1:0] cnt_q;
  logic [WORD_W-1:0] eff;
  logic              at_zero;

  assign eff       = wide ? cnt_q : {16'd0, cnt_q[15:0]};
  assign at_zero   = (eff == '0);
  assign wrap      = dec_tick && at_zero && !load_now;
  assign count_val = eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_now)   cnt_q <= load_data;
    else if (dec_tick)   cnt_q <= at_zero ? reload_val : eff - 32'd1;
  end

  // R3: without a tick or a load the count does not move
  a_r3_still_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_tick && !load_now) |=> $stable(cnt_q));
  // R6: a reload write lands in the count on the next edge
  a_r6_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (cnt_q == $past(load_data)));
endmodule

// File: rtl/ptm_freerun.sv
module ptm_freerun
  import ptm_pkg::*;
#(
  parameter int FRDIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               hold,
  input  logic [FRDIV_W-1:0] div,
  output logic [WORD_W-1:0]  free_val
);
  logic [FRDIV_W-1:0] dv_q;
  logic [WORD_W-1:0]  fc_q;
  logic               dv_hit;

  assign dv_hit   = (dv_q >= div);
  assign free_val = fc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= '0;
      fc_q <= '0;
    end else if (!enable) begin
      dv_q <= '0;
    end else if (!hold) begin
      if (dv_hit) begin
        dv_q <= '0;
        fc_q <= fc_q + 32'd1;
      end else begin
        dv_q <= dv_q + FRDIV_W'(1);
      end
    end
  end

  // R9: the free counter never skips a value
  a_r9_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fc_q - $past(fc_q)) <= 32'd1));
endmodule

// File: rtl/ptm_timer.sv
module ptm_timer
  import ptm_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PREDIV_W = 9,
  parameter int FRDIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_halt,
  output logic              irq
);
  logic [WORD_W-1:0]   reload_val, count_val, free_val;
  logic                reload_wr, ctrl_wr, wide, irq_en, run_en, dbg_en, free_en;
  logic [1:0]          scale;
  logic [FRDIV_W-1:0]  free_div;
  logic [PREDIV_W-1:0] prediv;
  logic                raw_flag, wrap, dec_tick, frozen;

  assign frozen = dbg_en && dbg_halt;
  assign irq    = raw_flag && irq_en;

  ptm_regs #(.ADDR_W(ADDR_W), .PREDIV_W(PREDIV_W), .FRDIV_W(FRDIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wrap(wrap), .count_val(count_val), .free_val(free_val),
    .reload_val(reload_val), .reload_wr(reload_wr), .ctrl_wr(ctrl_wr),
    .wide(wide), .scale(scale), .irq_en(irq_en), .run_en(run_en),
    .dbg_en(dbg_en), .free_en(free_en), .free_div(free_div),
    .prediv(prediv), .raw_flag(raw_flag)
  );

  ptm_tickgen #(.PREDIV_W(PREDIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .enable(run_en), .hold(frozen),
    .restart(reload_wr), .prediv(prediv), .scale(scale), .dec_tick(dec_tick)
  );

  ptm_down u_down (
    .clk(clk), .rst_n(rst_n), .dec_tick(dec_tick), .wide(wide),
    .load_now(reload_wr), .load_data(bus_wdata), .reload_val(reload_val),
    .count_val(count_val), .wrap(wrap)
  );

  ptm_freerun #(.FRDIV_W(FRDIV_W)) u_free (
    .clk(clk), .rst_n(rst_n), .enable(free_en), .hold(frozen),
    .div(free_div), .free_val(free_val)
  );

  // R10: a permitted debug halt freezes both counters
  a_r10_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !reload_wr && !ctrl_wr) |=> ($stable(count_val) && $stable(free_val)));
  // R4: a stopped timer produces no decrement tick
  a_r4_stopped_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !dec_tick);
endmodule

// File: tb/test_ptm_timer.sv
`timescale 1ns/1ps
module test_ptm_timer;
  localparam logic [5:0] A_RELOAD = 6'h00, A_COUNT = 6'h04, A_CTRL = 6'h08,
    A_ACK = 6'h0C, A_RAW = 6'h10, A_MASK = 6'h14, A_DEFER = 6'h18,
    A_PDV = 6'h1C, A_FREE = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, dbg_halt = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ptm_timer i_ptm_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_RELOAD, v); chk("R1 reload", v, 0);
    rd(A_COUNT, v);  chk("R1 count", v, 0);
    rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
    rd(A_RAW, v);    chk("R1 raw", v, 0);
    rd(A_MASK, v);   chk("R1 masked", v, 0);
    rd(A_DEFER, v);  chk("R1 defer", v, 0);
    rd(A_PDV, v);    chk("R1 prediv", v, 0);
    rd(A_FREE, v);   chk("R1 free", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_countdown;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_RELOAD, 5); wr(A_ACK, 0); wr(A_CTRL, 32'h82);
    rd(A_COUNT, v); chk("R3 start", v, 5);
    wait_cyc(1); rd(A_COUNT, v); chk("R3 first step", v, 4);
    wait_cyc(4); rd(A_COUNT, v); chk("R3 at zero", v, 0);
    rd(A_RAW, v); chk("R3 raw before wrap", v, 0);
    wait_cyc(1); rd(A_COUNT, v); chk("R3 reload", v, 5);
    rd(A_RAW, v); chk("R3 raw on wrap", v, 1);
    rd(A_MASK, v); chk("R8 masked off", v, 0);
    chk("R8 irq masked", {31'd0, irq}, 0);
    wr(A_ACK, 32'h1234); rd(A_RAW, v); chk("R8 ack clears", v, 0);
    wr(A_CTRL, 32'hA2); wait_cyc(8);
    rd(A_MASK, v); chk("R8 masked on", v, 1);
    chk("R8 irq on", {31'd0, irq}, 1);
    wr(A_CTRL, 0); wr(A_ACK, 0);
    chk("R8 irq after ack", {31'd0, irq}, 0);
  endtask

  task automatic t_rate;
    logic [31:0] v;
    wr(A_PDV, 2); wr(A_RELOAD, 100); wr(A_CTRL, 32'h82);
    wait_cyc(2); rd(A_COUNT, v); chk("R4 prediv early", v, 100);
    wait_cyc(1); rd(A_COUNT, v); chk("R4 prediv first", v, 99);
    wait_cyc(3); rd(A_COUNT, v); chk("R4 prediv second", v, 98);
    wr(A_CTRL, 0); wr(A_PDV, 0); wr(A_RELOAD, 100); wr(A_CTRL, 32'h86);
    wait_cyc(15); rd(A_COUNT, v); chk("R4 div16 early", v, 100);
    wait_cyc(1); rd(A_COUNT, v); chk("R4 div16 tick", v, 99);
    wr(A_CTRL, 0); wr(A_RELOAD, 100); wr(A_CTRL, 32'h8A);
    wait_cyc(255); rd(A_COUNT, v); chk("R4 div256 early", v, 100);
    wait_cyc(1); rd(A_COUNT, v); chk("R4 div256 tick", v, 99);
    wr(A_CTRL, 0); wr(A_RELOAD, 100); wr(A_CTRL, 32'h8E);
    wait_cyc(255); rd(A_COUNT, v); chk("R4 spare early", v, 100);
    wait_cyc(1); rd(A_COUNT, v); chk("R4 spare tick", v, 99);
    wr(A_CTRL, 0); wait_cyc(5); rd(A_COUNT, v); chk("R4 stopped holds", v, 99);
    wr(A_PDV, 32'hFFFF); rd(A_PDV, v); chk("R4 prediv width", v, 32'h1FF);
    wr(A_PDV, 0);
  endtask

  task automatic t_width;
    logic [31:0] v;
    wr(A_ACK, 0); wr(A_RELOAD, 32'h0003_0001);
    rd(A_COUNT, v); chk("R5 narrow read", v, 1);
    wr(A_CTRL, 32'h80);
    wait_cyc(1); rd(A_COUNT, v); chk("R5 narrow zero", v, 0);
    wait_cyc(1); rd(A_COUNT, v); chk("R5 narrow reload", v, 1);
    rd(A_RAW, v); chk("R5 narrow wrap", v, 1);
    wr(A_CTRL, 0); wr(A_ACK, 0); wr(A_RELOAD, 32'h0003_0001); wr(A_CTRL, 32'h82);
    wait_cyc(2); rd(A_COUNT, v); chk("R5 wide count", v, 32'h0002_FFFF);
    rd(A_RAW, v); chk("R5 wide no wrap", v, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_defer;
    logic [31:0] v;
    wr(A_ACK, 0); wr(A_RELOAD, 7); wr(A_DEFER, 3);
    rd(A_COUNT, v);  chk("R7 count kept", v, 7);
    rd(A_RELOAD, v); chk("R7 reload readback", v, 3);
    rd(A_DEFER, v);  chk("R7 defer readback", v, 3);
    wr(A_CTRL, 32'h82);
    wait_cyc(7); rd(A_COUNT, v); chk("R7 reached zero", v, 0);
    wait_cyc(1); rd(A_COUNT, v); chk("R7 deferred reload", v, 3);
    wr(A_CTRL, 0); wr(A_RELOAD, 9); wr(A_COUNT, 32'h55);
    rd(A_COUNT, v); chk("R2 count write ignored", v, 9);
    rd(A_RELOAD, v); chk("R6 reload value", v, 9);
    wr(6'h01, 32'h77); rd(A_RELOAD, v); chk("R2 unaligned write ignored", v, 9);
    rd(6'h01, v); chk("R2 unaligned read", v, 0);
    rd(A_ACK, v); chk("R2 ack reads zero", v, 0);
  endtask

  task automatic t_free;
    logic [31:0] v;
    wr(A_CTRL, 32'h200);
    rd(A_FREE, v); chk("R9 start", v, 0);
    wait_cyc(5); rd(A_FREE, v); chk("R9 div0 rate", v, 5);
    wr(A_CTRL, 32'h0003_0200);
    rd(A_FREE, v); chk("R9 after ctrl", v, 7);
    wait_cyc(3); rd(A_FREE, v); chk("R9 div3 early", v, 7);
    wait_cyc(1); rd(A_FREE, v); chk("R9 div3 step", v, 8);
    wait_cyc(4); rd(A_FREE, v); chk("R9 div3 next", v, 9);
    wr(A_CTRL, 0); rd(A_FREE, v);
    wait_cyc(6); begin logic [31:0] w; rd(A_FREE, w); chk("R9 holds disabled", w, v); end
  endtask

  task automatic t_halt;
    logic [31:0] c0, f0, v;
    wr(A_RELOAD, 50);
    dbg_halt = 1'b1;
    wr(A_CTRL, 32'h382);
    rd(A_COUNT, c0); rd(A_FREE, f0);
    chk("R10 count before halt", c0, 50);
    wait_cyc(10);
    rd(A_COUNT, v); chk("R10 count frozen", v, 50);
    rd(A_FREE, v);  chk("R10 free frozen", v, f0);
    dbg_halt = 1'b0;
    wait_cyc(3);
    rd(A_COUNT, v); chk("R10 count resumes", v, 47);
    rd(A_FREE, v);  chk("R10 free resumes", v, f0 + 3);
    dbg_halt = 1'b1;
    wr(A_CTRL, 32'h282);
    rd(A_COUNT, c0);
    wait_cyc(2); rd(A_COUNT, v); chk("R10 halt not permitted", v, c0 - 2);
    dbg_halt = 1'b0;
    wr(A_CTRL, 0);
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R11 ctrl mask", v, 32'h00FF_03AE);
    wr(A_CTRL, 0);
    rd(A_CTRL, v); chk("R11 ctrl cleared", v, 0);
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_countdown;
    t_rate;
    t_width;
    t_defer;
    t_free;
    t_halt;
    t_ctrl_mask;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule